// File: doc/BRIEF.md
# Radio reference divider chain

This block turns a 4 MHz reference clock into the fixed low-rate signals a broadcast-radio synthesizer needs. A single cascade of modulo counters (divide by 8, then 40, then 25, then 10) yields a 500 kHz square clock for an external tuning controller, a 12.5 kHz FM comparison grid, a 500 Hz AM comparison grid and a 50 Hz square tick for time-of-day keeping. Each stage advances only on the last count of the stage before it. Every slower boundary therefore lands exactly on a boundary of every faster one.

A band-select input chooses which comparison grid drives the phase-comparator reference output. That output is a strobe one input clock wide. The band bit is sampled on every clock edge. Because each 500 Hz boundary is also a 12.5 kHz boundary, switching bands can never shorten or split a strobe. The first strobe after a switch comes at the next boundary of the newly chosen grid.

Top module: `radio_ref_divider`

Time below is counted in input clock edges since reset was released. `t` is the number of rising edges sampled with the reset input high since the last edge sampled with it low, so `t` = 0 right after release.

## Requirements
- R1: `ctrl_clk_o` is low when `t mod 8` is below 4 and high otherwise, giving 500 kHz from 4 MHz with a 50% duty cycle.
- R2: `tod_o` is low when `t mod 80000` is below 40000 and high otherwise, giving 50 Hz. It changes only right after a 500 Hz boundary.
- R3: When `band_fm_i` is 1 (FM) at the edge that produces cycle `t`, `cmp_ref_o` is high in that cycle exactly when `t` > 0 and `t mod 320` = 0 (12.5 kHz).
- R4: When `band_fm_i` is 0 (AM) at that edge, `cmp_ref_o` is high exactly when `t` > 0 and `t mod 8000` = 0 (500 Hz).
- R5: The band bit is taken anew at every edge. After a change, no strobe appears until the next boundary of the newly selected grid, and no strobe is shortened or doubled.
- R6: Reset is synchronous and active low. Every edge that samples `rst_ni` low clears all outputs and counters, and counting restarts at `t` = 0 on release.
- R7: `cmp_ref_o` is never high in two consecutive cycles.
- R8: Every `cmp_ref_o` strobe lies on a 12.5 kHz boundary, where `ctrl_clk_o` has just fallen and is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref_i | input | 1 | 4 MHz reference clock |
| rst_ni | input | 1 | synchronous reset, active low |
| band_fm_i | input | 1 | band select: 1 = FM (12.5 kHz grid), 0 = AM (500 Hz grid) |
| ctrl_clk_o | output | 1 | 500 kHz square clock for the external controller |
| cmp_ref_o | output | 1 | one-cycle phase-comparator reference strobe of the selected band |
| tod_o | output | 1 | 50 Hz square time-of-day tick |

## Verification
The embedded assertions check these properties on every cycle:
- The controller clock falls right after each FM boundary.
- The AM boundary never occurs without an FM boundary.
- The time-of-day output moves only after an AM boundary.
- The reference strobe is one cycle wide, sits on the FM grid and is cleared by reset.

Only the bench's long sweeps can show the absolute rates and phases. These include the 40000-cycle half period of the tick and the exact strobe cycles under each band. The same holds for the absence of runt or lost strobes when the band toggles mid-period, and the clean restart after a reset in the middle of a run.

// File: rtl/radio_ref_pkg.sv
package radio_ref_pkg;

    // Band selection: value of the band input.
    typedef enum logic {
        BAND_AM = 1'b0,
        BAND_FM = 1'b1
    } band_e;

    // Default cascade ratios for a 4 MHz input.
    localparam int unsigned DEF_DIV_CTRL = 8;   // 4 MHz -> 500 kHz
    localparam int unsigned DEF_DIV_FM   = 40;  // 500 kHz -> 12.5 kHz
    localparam int unsigned DEF_DIV_AM   = 25;  // 12.5 kHz -> 500 Hz
    localparam int unsigned DEF_DIV_TOD  = 10;  // 500 Hz -> 50 Hz

endpackage

// File: rtl/ref_div_chain.sv
module ref_div_chain #(
    parameter int unsigned DIV_A = 8,
    parameter int unsigned DIV_B = 40,
    parameter int unsigned DIV_C = 25,
    parameter int unsigned DIV_D = 10
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic ctrl_sq_o,
    output logic fm_stb_o,
    output logic am_stb_o,
    output logic tod_sq_o
);
    localparam int unsigned WA = (DIV_A > 2) ? $clog2(DIV_A) : 1;
    localparam int unsigned WB = (DIV_B > 2) ? $clog2(DIV_B) : 1;
    localparam int unsigned WC = (DIV_C > 2) ? $clog2(DIV_C) : 1;
    localparam int unsigned WD = (DIV_D > 2) ? $clog2(DIV_D) : 1;

    localparam logic [WA-1:0] A_LAST = WA'(DIV_A - 1);
    localparam logic [WB-1:0] B_LAST = WB'(DIV_B - 1);
    localparam logic [WC-1:0] C_LAST = WC'(DIV_C - 1);
    localparam logic [WD-1:0] D_LAST = WD'(DIV_D - 1);
    // High phase begins at the upper half of the stage count.
    localparam logic [WA-1:0] A_HALF = WA'((DIV_A + 1) / 2);
    localparam logic [WD-1:0] D_HALF = WD'((DIV_D + 1) / 2);

    typedef struct packed {
        logic [WA-1:0] cnt_a;
        logic [WB-1:0] cnt_b;
        logic [WC-1:0] cnt_c;
        logic [WD-1:0] cnt_d;
        logic          ctrl;
        logic          tod;
    } chain_t;

    chain_t s_d, s_q;
    logic   wrap_a, wrap_b, wrap_c;

    // Carry chain: each stage wraps only when all faster stages wrap.
    assign wrap_a = (s_q.cnt_a == A_LAST);
    assign wrap_b = wrap_a && (s_q.cnt_b == B_LAST);
    assign wrap_c = wrap_b && (s_q.cnt_c == C_LAST);

    always_comb begin
        s_d = s_q;
        s_d.cnt_a = wrap_a ? '0 : s_q.cnt_a + 1'b1;
        if (wrap_a) begin
            s_d.cnt_b = (s_q.cnt_b == B_LAST) ? '0 : s_q.cnt_b + 1'b1;
        end
        if (wrap_b) begin
            s_d.cnt_c = (s_q.cnt_c == C_LAST) ? '0 : s_q.cnt_c + 1'b1;
        end
        if (wrap_c) begin
            s_d.cnt_d = (s_q.cnt_d == D_LAST) ? '0 : s_q.cnt_d + 1'b1;
        end
        // Registered squares follow the next count so they never glitch.
        s_d.ctrl = (s_d.cnt_a >= A_HALF);
        s_d.tod  = (s_d.cnt_d >= D_HALF);
        if (!rst_ni) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        s_q <= s_d;
    end

    assign ctrl_sq_o = s_q.ctrl;
    assign tod_sq_o  = s_q.tod;
    assign fm_stb_o  = wrap_b;
    assign am_stb_o  = wrap_c;

    // R1: the controller clock falls on the cycle after every FM boundary.
    p_ctrl_falls_after_fm_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fm_stb_o |=> $fell(ctrl_sq_o));

    // R4: the AM grid is a subset of the FM grid.
    p_am_inside_fm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        am_stb_o |-> fm_stb_o);

    // R2: the time-of-day square moves only right after an AM boundary.
    p_tod_moves_on_am_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$stable(tod_sq_o) && $past(rst_ni)) |-> $past(am_stb_o));

endmodule

// File: rtl/ref_band_sel.sv
module ref_band_sel
    import radio_ref_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic band_fm_i,
    input  logic fm_stb_i,
    input  logic am_stb_i,
    output logic ref_o
);
    typedef struct packed {
        logic pulse;
    } sel_t;

    sel_t  s_d, s_q;
    band_e band;

    assign band = band_e'(band_fm_i);

    always_comb begin
        s_d = s_q;
        unique case (band)
            BAND_FM: s_d.pulse = fm_stb_i;
            BAND_AM: s_d.pulse = am_stb_i;
            default: s_d.pulse = 1'b0;
        endcase
        if (!rst_ni) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        s_q <= s_d;
    end

    assign ref_o = s_q.pulse;

    // R7: a reference strobe lasts a single input clock.
    p_ref_one_wide_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ref_o |=> !ref_o);

    // R8: every strobe, whichever band, sits on the 12.5 kHz grid.
    p_ref_on_fm_grid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ref_o |-> $past(fm_stb_i));

    // R6: an edge with reset low leaves the strobe cleared.
    p_reset_clears_ref_r6: assert property (@(posedge clk_i)
        !rst_ni |=> !ref_o);

endmodule

// File: rtl/radio_ref_divider.sv
module radio_ref_divider
    import radio_ref_pkg::*;
#(
    parameter int unsigned DIV_CTRL = DEF_DIV_CTRL,
    parameter int unsigned DIV_FM   = DEF_DIV_FM,
    parameter int unsigned DIV_AM   = DEF_DIV_AM,
    parameter int unsigned DIV_TOD  = DEF_DIV_TOD
) (
    input  logic clk_ref_i,
    input  logic rst_ni,
    input  logic band_fm_i,
    output logic ctrl_clk_o,
    output logic cmp_ref_o,
    output logic tod_o
);
    logic fm_stb, am_stb;

    ref_div_chain #(
        .DIV_A (DIV_CTRL),
        .DIV_B (DIV_FM),
        .DIV_C (DIV_AM),
        .DIV_D (DIV_TOD)
    ) u_chain (
        .clk_i     (clk_ref_i),
        .rst_ni    (rst_ni),
        .ctrl_sq_o (ctrl_clk_o),
        .fm_stb_o  (fm_stb),
        .am_stb_o  (am_stb),
        .tod_sq_o  (tod_o)
    );

    ref_band_sel u_sel (
        .clk_i     (clk_ref_i),
        .rst_ni    (rst_ni),
        .band_fm_i (band_fm_i),
        .fm_stb_i  (fm_stb),
        .am_stb_i  (am_stb),
        .ref_o     (cmp_ref_o)
    );

endmodule

// File: tb/tb_radio_ref_divider.sv
`timescale 1ns/1ps
module tb_radio_ref_divider;
    logic clk_ref = 1'b0;
    logic rst_n   = 1'b0;
    logic band_fm = 1'b1;
    logic ctrl_clk, cmp_ref, tod;

    int unsigned t_m      = 0;
    logic        edge_band = 1'b1;
    logic        edge_rst  = 1'b0;
    logic        prev_ref  = 1'b0;
    int          total     = 0;
    int          bad       = 0;
    bit          done      = 1'b0;
    string       ref_tag   = "R3";

    radio_ref_divider dut (
        .clk_ref_i  (clk_ref),
        .rst_ni     (rst_n),
        .band_fm_i  (band_fm),
        .ctrl_clk_o (ctrl_clk),
        .cmp_ref_o  (cmp_ref),
        .tod_o      (tod)
    );

    always #2.5 clk_ref = ~clk_ref;

    task automatic check(input logic got, input logic exp, input string tag, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s at t=%0d: actual=%0b expected=%0b", tag, what, t_m, got, exp);
        end
    endtask

    // One input clock: advance the bench model, then compare at the falling edge.
    task automatic step();
        logic exp_ctrl, exp_tod, exp_ref;
        int unsigned per;
        @(posedge clk_ref);
        edge_band = band_fm;
        edge_rst  = rst_n;
        if (edge_rst) t_m++;
        else          t_m = 0;
        @(negedge clk_ref);
        if (!edge_rst) begin
            check(ctrl_clk, 1'b0, "R6", "ctrl_clk_o in reset");
            check(tod,      1'b0, "R6", "tod_o in reset");
            check(cmp_ref,  1'b0, "R6", "cmp_ref_o in reset");
        end else begin
            per      = edge_band ? 320 : 8000;
            exp_ctrl = ((t_m % 8) >= 4);
            exp_tod  = ((t_m % 80000) >= 40000);
            exp_ref  = (t_m > 0) && ((t_m % per) == 0);
            check(ctrl_clk, exp_ctrl, "R1", "ctrl_clk_o");
            check(tod,      exp_tod,  "R2", "tod_o");
            check(cmp_ref,  exp_ref,  ref_tag, "cmp_ref_o");
            if (prev_ref) check(cmp_ref, 1'b0, "R7", "strobe width");
            if (cmp_ref)  check(ctrl_clk, 1'b0, "R8", "ctrl_clk_o at strobe");
        end
        prev_ref = cmp_ref;
    endtask

    initial begin
        // R6: reset state at start.
        repeat (4) step();
        rst_n = 1'b1;
        // R3: FM band past the first full 50 Hz period (R2 fall at 80000).
        ref_tag = "R3";
        repeat (85000) step();
        // R4: switch to AM mid-period (t mod 320 = 200): no runt strobe.
        band_fm = 1'b0;
        ref_tag = "R4";
        repeat (20000) step();
        // R5: band toggling at irregular points.
        ref_tag = "R5";
        for (int k = 0; k < 30; k++) begin
            band_fm = ~band_fm;
            repeat (700 + k * 37) step();
        end
        // R6: reset mid-run, then restart from zero.
        rst_n = 1'b0;
        repeat (3) step();
        rst_n   = 1'b1;
        band_fm = 1'b1;
        ref_tag = "R3";
        repeat (2000) step();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk_ref);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule